// File: doc/BRIEF.md
# Multicycle Load/Store/Branch Processor Core

This block is a small 32-bit processor that runs a subset of a common RISC instruction set: register-to-register arithmetic and logic, load word, store word and branch on equal. It does not overlap instructions. A control state machine takes each instruction through a fixed series of phases: fetch, decode with register read, execute, memory or write-back, and a final load write-back. Each phase fits in one clock cycle, so an instruction takes between two and five cycles.

Instructions and data share one memory port. The port carries a byte address and write data, and it returns read data combinationally in the same cycle. During fetch the address comes from the program counter. During a data access it comes from the ALU result register. The core keeps an instruction register, a memory data register, two operand registers and an ALU result register. The register file has 32 entries, two read ports and one write port.

Top module: `mc_core`

## Requirements
- R1: An active-low asynchronous reset clears the PC and every register to zero and puts the core in its fetch phase. mem_addr_o is 0 and mem_we_o is 0 while reset is held and right after it is released.
- R2: Instruction fields are opcode IR[31:26], rs IR[25:21], rt IR[20:16], rd IR[15:11], shamt IR[10:6], funct IR[5:0] and immediate IR[15:0]. In fetch, mem_addr_o equals the PC as a byte address, and the memory word index is mem_addr_o[31:2]. IR takes mem_rdata_i and the PC advances by 4.
- R3: Cycle counts by opcode are: 0x04 (branch on equal) 3 cycles; 0x00 (register op) and 0x2B (store) 4 cycles; 0x23 (load) 5 cycles. Any other opcode takes 2 cycles.
- R4: A register op with shamt 0 writes to rd in its fourth cycle. The result depends on funct: 0x20 gives rs+rt, 0x22 gives rs-rt, 0x24 gives rs AND rt, 0x25 gives rs OR rt, and 0x2A gives 1 when rs<rt as signed numbers and 0 otherwise. Any other funct, or a nonzero shamt, writes no register.
- R5: A load drives mem_addr_o = rs + sign-extended immediate in its fourth cycle. In its fifth cycle it writes the word read there into rt.
- R6: A store raises mem_we_o for exactly its fourth cycle. In that cycle mem_addr_o = rs + sign-extended immediate and mem_wdata_o = the value of rt.
- R7: A branch on equal moves the PC to (branch address + 4) + (sign-extended immediate << 2) when rs equals rt, and to branch address + 4 otherwise. Negative offsets branch backwards.
- R8: Writes to register 0 are discarded, and register 0 always reads as zero.
- R9: An unsupported opcode changes no register and no memory word. Its only effect is the PC advance made by fetch.
- R10: mem_we_o is 0 in every cycle except the fourth cycle of a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 32 | Byte address for fetch or data access |
| mem_wdata_o | output | 32 | Store data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 32 | Memory read data, valid in the same cycle |

## Verification
- **Wrong PC or wrong phase sequence:** this shows up at the very next fetch. Either the fetch address is wrong, or it arrives one cycle early or late. It is therefore caught within at most five cycles.
- **Wrong register or data-memory contents:** these show nothing at the ports until a later store carries the bad value out. The bench therefore stores every register it has used at the end of the program. It also compares the whole data area against a reference model of the instruction set.
- **Stray writes:** a write strobe outside the store cycle is seen in the cycle it happens.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [5:0] OPC_ALU   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BREQ  = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef enum logic [3:0] {
    S_FETCH,
    S_DECODE,
    S_EX_ADDR,
    S_EX_R,
    S_EX_BR,
    S_MEM_RD,
    S_MEM_WR,
    S_R_WB,
    S_LD_WB
  } phase_e;

  typedef enum logic [1:0] {
    SRCB_REG,
    SRCB_STEP,
    SRCB_IMM,
    SRCB_BRANCH
  } srcb_e;

  typedef struct packed {
    logic    pc_we;
    logic    pc_from_aluout;
    logic    br_cond;
    logic    ir_we;
    logic    ab_we;
    logic    aluout_we;
    logic    mdr_we;
    logic    srca_reg;
    srcb_e   srcb;
    alu_op_e alu_op;
    logic    addr_aluout;
    logic    mem_we;
    logic    rf_we;
    logic    rf_dst_rd;
    logic    rf_from_mdr;
  } ctrl_t;

  typedef struct packed {
    logic    ok;
    alu_op_e op;
  } fn_dec_t;

  function automatic fn_dec_t decode_funct(input logic [5:0] fn, input logic [4:0] shamt);
    fn_dec_t r;
    r.ok = (shamt == 5'd0);
    case (fn)
      FN_ADD:  r.op = ALU_ADD;
      FN_SUB:  r.op = ALU_SUB;
      FN_AND:  r.op = ALU_AND;
      FN_OR:   r.op = ALU_OR;
      FN_SLT:  r.op = ALU_SLT;
      default: begin
        r.ok = 1'b0;
        r.op = ALU_ADD;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     raddr_a_i,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i
);

  logic [DATA_W-1:0] regs_q [DEPTH];

  // entry 0 is never written, so it keeps its reset value of zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  p_r0_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[0] == '0);

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] y_o,
  output logic              zero_o
);

  logic lt;
  assign lt = $signed(a_i) < $signed(b_i);

  always_comb begin
    case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(DATA_W-1){1'b0}}, lt};
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);

  always_comb begin
    if (op_i == ALU_SLT) begin
      p_slt_bool_r4: assert (y_o[DATA_W-1:1] == '0);
    end
  end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  input  logic [4:0] shamt_i,
  output ctrl_t      ctrl_o,
  output phase_e     phase_o
);

  phase_e  phase_q, phase_d;
  fn_dec_t fn_dec;
  logic    op_known;

  assign fn_dec   = decode_funct(funct_i, shamt_i);
  assign op_known = opcode_i inside {OPC_ALU, OPC_LOAD, OPC_STORE, OPC_BREQ};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= S_FETCH;
    else         phase_q <= phase_d;
  end

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.srcb   = SRCB_REG;
    ctrl_o.alu_op = ALU_ADD;
    phase_d       = phase_q;
    case (phase_q)
      S_FETCH: begin
        ctrl_o.ir_we = 1'b1;
        ctrl_o.pc_we = 1'b1;
        ctrl_o.srcb  = SRCB_STEP;
        phase_d      = S_DECODE;
      end
      S_DECODE: begin
        // operand read and branch target computed before the opcode is known
        ctrl_o.ab_we     = 1'b1;
        ctrl_o.aluout_we = 1'b1;
        ctrl_o.srcb      = SRCB_BRANCH;
        case (opcode_i)
          OPC_ALU:             phase_d = S_EX_R;
          OPC_LOAD, OPC_STORE: phase_d = S_EX_ADDR;
          OPC_BREQ:            phase_d = S_EX_BR;
          default:             phase_d = S_FETCH;
        endcase
      end
      S_EX_ADDR: begin
        ctrl_o.srca_reg  = 1'b1;
        ctrl_o.srcb      = SRCB_IMM;
        ctrl_o.aluout_we = 1'b1;
        phase_d          = (opcode_i == OPC_LOAD) ? S_MEM_RD : S_MEM_WR;
      end
      S_EX_R: begin
        ctrl_o.srca_reg  = 1'b1;
        ctrl_o.alu_op    = fn_dec.op;
        ctrl_o.aluout_we = 1'b1;
        phase_d          = S_R_WB;
      end
      S_EX_BR: begin
        ctrl_o.srca_reg       = 1'b1;
        ctrl_o.alu_op         = ALU_SUB;
        ctrl_o.br_cond        = 1'b1;
        ctrl_o.pc_from_aluout = 1'b1;
        phase_d               = S_FETCH;
      end
      S_MEM_RD: begin
        ctrl_o.addr_aluout = 1'b1;
        ctrl_o.mdr_we      = 1'b1;
        phase_d            = S_LD_WB;
      end
      S_MEM_WR: begin
        ctrl_o.addr_aluout = 1'b1;
        ctrl_o.mem_we      = 1'b1;
        phase_d            = S_FETCH;
      end
      S_R_WB: begin
        ctrl_o.rf_we     = fn_dec.ok;
        ctrl_o.rf_dst_rd = 1'b1;
        phase_d          = S_FETCH;
      end
      S_LD_WB: begin
        ctrl_o.rf_we       = 1'b1;
        ctrl_o.rf_from_mdr = 1'b1;
        phase_d            = S_FETCH;
      end
      default: phase_d = S_FETCH;
    endcase
  end

  assign phase_o = phase_q;

  p_ld_seq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == S_MEM_RD |=> phase_q == S_LD_WB);

  p_br_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == S_EX_BR |=> phase_q == S_FETCH);

  p_bad_op_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == S_DECODE && !op_known) |=> phase_q == S_FETCH);

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_CNT = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  localparam int unsigned REG_AW = $clog2(REG_CNT);
  localparam int unsigned STEP   = DATA_W / 8;

  logic [DATA_W-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;
  logic [DATA_W-1:0] imm_ext, srca, srcb, alu_y, rf_a, rf_b, rf_wdata;
  logic [REG_AW-1:0] rf_waddr;
  logic              alu_zero, pc_load;
  ctrl_t             ctl;
  phase_e            phase;

  mc_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (ir_q[31:26]),
    .funct_i  (ir_q[5:0]),
    .shamt_i  (ir_q[10:6]),
    .ctrl_o   (ctl),
    .phase_o  (phase)
  );

  assign imm_ext = {{(DATA_W-16){ir_q[15]}}, ir_q[15:0]};

  always_comb begin
    case (ctl.srcb)
      SRCB_REG:  srcb = b_q;
      SRCB_STEP: srcb = DATA_W'(STEP);
      SRCB_IMM:  srcb = imm_ext;
      default:   srcb = {imm_ext[DATA_W-3:0], 2'b00};
    endcase
  end

  assign srca = ctl.srca_reg ? a_q : pc_q;

  mc_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i    (srca),
    .b_i    (srcb),
    .op_i   (ctl.alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  assign rf_waddr = ctl.rf_dst_rd ? ir_q[15:11] : ir_q[20:16];
  assign rf_wdata = ctl.rf_from_mdr ? mdr_q : aluout_q;

  mc_regfile #(.DATA_W(DATA_W), .DEPTH(REG_CNT)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raddr_a_i (ir_q[25:21]),
    .raddr_b_i (ir_q[20:16]),
    .rdata_a_o (rf_a),
    .rdata_b_o (rf_b),
    .we_i      (ctl.rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata)
  );

  assign pc_load = ctl.pc_we | (ctl.br_cond & alu_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
      mdr_q    <= '0;
    end else begin
      if (pc_load)       pc_q     <= ctl.pc_from_aluout ? aluout_q : alu_y;
      if (ctl.ir_we)     ir_q     <= mem_rdata_i;
      if (ctl.ab_we)     a_q      <= rf_a;
      if (ctl.ab_we)     b_q      <= rf_b;
      if (ctl.aluout_we) aluout_q <= alu_y;
      if (ctl.mdr_we)    mdr_q    <= mem_rdata_i;
    end
  end

  assign mem_addr_o  = ctl.addr_aluout ? aluout_q : pc_q;
  assign mem_wdata_o = b_q;
  assign mem_we_o    = ctl.mem_we;

  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == S_FETCH |=> pc_q == $past(pc_q) + DATA_W'(STEP));

  p_ir_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase != S_FETCH |=> $stable(ir_q));

  p_pc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == S_EX_BR && !alu_zero) |=> $stable(pc_q));

  p_br_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == S_EX_BR && alu_zero) |=> pc_q == $past(aluout_q));

  p_we_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

endmodule

// File: tb/test_mc_core.sv
`timescale 1ns/1ps
module test_mc_core;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;

  logic [31:0] mem     [256];
  logic [31:0] ref_mem [256];
  logic [31:0] ref_rf  [32];
  logic [31:0] ref_pc;
  logic [31:0] epi_addr;
  int          tests = 0;
  int          fails = 0;
  int          wp = 0;

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];

  mc_core i_mc_core (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic bit alu_ref(logic [5:0] fn, logic [4:0] sh, logic [31:0] a,
                                 logic [31:0] b, output logic [31:0] y);
    y = '0;
    if (sh != 5'd0) return 1'b0;
    case (fn)
      6'h20:   y = a + b;
      6'h22:   y = a - b;
      6'h24:   y = a & b;
      6'h25:   y = a | b;
      6'h2A:   y = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 1'b0;
    endcase
    return 1'b1;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic put(logic [31:0] w);
    mem[wp] = w;
    wp++;
  endtask

  // memory write applied at the sampling point, before the capturing edge
  task automatic next_cycle();
    if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
    @(negedge clk);
  endtask

  task automatic exec_one(inout string ftag);
    logic [31:0] ins, ext, a, b, ea, nxt, y;
    logic [5:0]  op;
    int          rs, rt, rd, ncyc;
    bit          ok;
    string       ntag, stag;
    ins  = ref_mem[ref_pc[9:2]];
    op   = ins[31:26];
    rs   = int'(ins[25:21]);
    rt   = int'(ins[20:16]);
    rd   = int'(ins[15:11]);
    ext  = {{16{ins[15]}}, ins[15:0]};
    a    = ref_rf[rs];
    b    = ref_rf[rt];
    ea   = a + ext;
    nxt  = ref_pc + 32'd4;
    case (op)
      6'h00: begin ncyc = 4; ntag = "R2"; end
      6'h23: begin ncyc = 5; ntag = "R3"; end
      6'h2B: begin ncyc = 4; ntag = "R2"; end
      6'h04: begin
        ncyc = 3; ntag = "R7";
        if (a == b) nxt = ref_pc + 32'd4 + (ext << 2);
      end
      default: begin ncyc = 2; ntag = "R9"; end
    endcase
    chk(mem_addr == ref_pc, ftag, "fetch address", mem_addr, ref_pc);
    chk(mem_we == 1'b0, "R10", "strobe in fetch", 32'(mem_we), 32'd0);
    for (int c = 2; c <= ncyc; c++) begin
      next_cycle();
      if (op == 6'h2B && c == 4) begin
        chk(mem_we == 1'b1, "R6", "store strobe", 32'(mem_we), 32'd1);
        chk(mem_addr == ea, "R6", "store address", mem_addr, ea);
        stag = (rt == 0) ? "R8" : ((ref_pc >= epi_addr) ? "R4" : "R6");
        chk(mem_wdata == b, stag, "store data", mem_wdata, b);
      end else begin
        chk(mem_we == 1'b0, "R10", "strobe outside store", 32'(mem_we), 32'd0);
        if (op == 6'h23 && c == 4) chk(mem_addr == ea, "R5", "load address", mem_addr, ea);
      end
    end
    case (op)
      6'h00: begin
        ok = alu_ref(ins[5:0], ins[10:6], a, b, y);
        if (ok && rd != 0) ref_rf[rd] = y;
      end
      6'h23: if (rt != 0) ref_rf[rt] = ref_mem[ea[9:2]];
      6'h2B: ref_mem[ea[9:2]] = b;
      default: ;
    endcase
    ref_pc = nxt;
    ftag   = ntag;
    next_cycle();
  endtask

  initial begin
    int unsigned seed;
    int          sel, rs, rt, rd, sh, fn, guard;
    string       ftag;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 128; i < 256; i++) mem[i] = $urandom;
    mem[192] = 32'h0000_0300;
    // prologue: load r1..r7 from the data area
    for (int i = 1; i <= 7; i++) put(enc_i(6'h23, 0, i, 4 * (127 + i)));
    // directed corners
    put(enc_r(1, 2, 0, 0, 6'h20));          // R8: write to r0
    put(enc_i(6'h2B, 0, 0, 4 * 240));       // R8: r0 stored as zero
    put(enc_i(6'h04, 0, 0, 2));             // R7: forward taken
    put(enc_i(6'h04, 0, 0, 2));             // reached backwards
    put(enc_i(6'h2B, 0, 1, 4 * 241));       // skipped
    put(enc_i(6'h04, 0, 0, -3));            // R7: backward taken
    put(enc_i(6'h04, 1, 2, 1));             // R7: compare of r1, r2
    put(enc_i(6'h23, 0, 8, 4 * 192));       // r8 = 0x300
    put(enc_i(6'h2B, 8, 3, -4));            // R6: negative offset
    put(enc_i(6'h23, 8, 9, 8));             // R5: base register plus offset
    put(enc_i(6'h2F, 0, 1, 4 * 242));       // R9: looks like a store
    put(enc_i(6'h3F, 3, 4, 16'h1234));      // R9
    put(enc_r(1, 2, 2, 0, 6'h27));          // R4: unsupported funct
    put(enc_r(1, 2, 3, 4, 6'h20));          // R4: nonzero shamt
    for (int k = 0; k < 85; k++) begin
      sel = $urandom_range(99);
      rs  = $urandom_range(9);
      rt  = $urandom_range(9);
      rd  = $urandom_range(9);
      if (sel < 40) begin
        case ($urandom_range(5))
          0: fn = 32'h20;
          1: fn = 32'h22;
          2: fn = 32'h24;
          3: fn = 32'h25;
          4: fn = 32'h2A;
          default: fn = 32'h27;
        endcase
        sh = ($urandom_range(9) == 0) ? 1 : 0;
        put(enc_r(rs, rt, rd, sh, fn));
      end else if (sel < 60) begin
        put(enc_i(6'h23, 0, rt, 4 * $urandom_range(229, 128)));
      end else if (sel < 80) begin
        put(enc_i(6'h2B, 0, rt, 4 * $urandom_range(229, 160)));
      end else if (sel < 95) begin
        put(enc_i(6'h04, rs, ($urandom_range(1) == 1) ? rs : rt, $urandom_range(3)));
      end else begin
        put(enc_i(6'h3F, rs, rt, $urandom_range(16'hFFFF)));
      end
    end
    // epilogue: dump r1..r10 (r10 is never written, so it still holds its R1 reset value)
    epi_addr = 32'(4 * wp);
    for (int i = 1; i <= 10; i++) put(enc_i(6'h2B, 0, i, 4 * (229 + i)));
    for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
    for (int i = 0; i < 32; i++) ref_rf[i] = '0;

    repeat (3) @(negedge clk);
    chk(mem_we == 1'b0, "R1", "strobe in reset", 32'(mem_we), 32'd0);
    chk(mem_addr == 32'd0, "R1", "address in reset", mem_addr, 32'd0);
    rst_ni = 1'b1;
    ref_pc = '0;
    ftag   = "R1";
    guard  = 0;
    while (ref_pc < 32'(4 * wp) && guard < 1000) begin
      exec_one(ftag);
      guard++;
    end
    chk(guard < 1000, "R3", "program completion", 32'(guard), 32'd1000);
    for (int i = 128; i < 256; i++)
      chk(mem[i] == ref_mem[i], (i >= 230) ? "R4" : "R6", "data word", mem[i], ref_mem[i]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R3 watchdog expired: actual %0d expected %0d", 20000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule